// File: doc/BRIEF.md
# Interrupt-Switched Global Register File

This block holds the eight global integer registers of a processor core together with a second, alternate set of eight globals reserved for interrupt service. A select bit inside a small processor-state word decides which set every global access reaches. When the trap unit signals entry into an interrupt-vector trap, the block saves the current state word on a four-deep trap stack and sets the select bit. From the next cycle on, the handler gets a private set of scratch registers without saving the normal globals to memory. When the handler exits, the block pops the saved state word. This brings back the earlier bank choice and the other state bits.

The register file has two combinational read ports and one write port, each addressed by a 3-bit global number. Global 0 is hard-wired to zero. A write is forwarded to a read of the same register in the same cycle. The trap level is counted from 0 to 4. An entry attempted at level 4 is refused and reported with a one-cycle overflow pulse. The surrounding core may also load the state word directly when no trap event is pending.

Top module: `gregTrapFile`

## Requirements
- R1: After reset, every global in both banks reads zero, the state word is zero and the trap level is zero.
- R2: A trap entry accepted at a level below 4 pushes the current state word, raises the level by one and sets bit 0 of the state word (the bank select) on the next cycle; the other state bits are unchanged.
- R3: A trap exit at a nonzero level, with no entry in the same cycle, lowers the level by one and restores the state word that the matching entry saved.
- R4: Reading global 0 returns zero in either bank, and a write to global 0 changes nothing.
- R5: While state bit 0 is 1, all reads and writes reach the alternate bank; while it is 0, they reach the normal bank; neither bank is changed through the other.
- R6: A trap entry at level 4 pushes nothing, leaves the level and the state word unchanged, and drives stackOvfl high for exactly the following cycle.
- R7: A read of the register being written in the same cycle returns the new write data.
- R8: A register write in the same cycle as a trap entry lands in the bank selected before the entry.
- R9: A trap exit at level 0 has no effect.
- R10: Priority within one cycle: trap entry over trap exit over state load; a state load takes effect only when neither trap request is present.
- R11: A state load alone replaces the state word with stateLdData on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trapEnter | input | 1 | Interrupt-vector trap taken this cycle |
| trapExit | input | 1 | Trap return this cycle |
| stateLd | input | 1 | Direct load of the state word |
| stateLdData | input | STATE_W | Value for a direct state load |
| wrEn | input | 1 | Global register write enable |
| wrAddr | input | 3 | Global register number to write |
| wrData | input | DATA_W | Write data |
| rdAddrA | input | 3 | Read port A register number |
| rdDataA | output | DATA_W | Read port A data |
| rdAddrB | input | 3 | Read port B register number |
| rdDataB | output | DATA_W | Read port B data |
| stateOut | output | STATE_W | Current state word; bit 0 selects the alternate bank |
| trapLevel | output | 3 | Current trap stack depth, 0 to 4 |
| stackOvfl | output | 1 | One-cycle pulse after a refused trap entry |

## Verification
Directed sequences place a write on a trap-entry cycle to separate the pre-trap bank from the post-trap bank. They read the same register number before and after the switch to show that the two banks are isolated. They exit back to level 0 to show that old contents come back. Extra cases push to level 4 and try one more entry, exit at level 0 while a load is requested, issue entry and exit together, and write and read the same register, including global 0, in one cycle. After these, a seeded random mix of writes, entries, exits and loads moves the level over its whole range while both read ports are compared every cycle with a bench model.

// File: rtl/gregPkg.sv
package gregPkg;
  // strobes from control to datapath
  typedef struct packed {
    logic bankSel;  // 1: alternate (interrupt) bank
    logic wrEn;     // qualified register write
  } dpStrobe_t;
endpackage

// File: rtl/gregCtrl.sv
module gregCtrl
  import gregPkg::*;
#(
  parameter int STATE_W = 4,
  parameter int IG_BIT  = 0,
  parameter int MAX_TL  = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 trapEnter,
  input  logic                 trapExit,
  input  logic                 stateLd,
  input  logic [STATE_W-1:0]   stateLdData,
  input  logic                 wrEn,
  output dpStrobe_t            strobe,
  output logic [STATE_W-1:0]   stateOut,
  output logic [$clog2(MAX_TL+1)-1:0] trapLevel,
  output logic                 stackOvfl
);
  localparam int TL_W  = $clog2(MAX_TL + 1);
  localparam int IDX_W = (MAX_TL > 1) ? $clog2(MAX_TL) : 1;

  logic [STATE_W-1:0] stateQ;
  logic [STATE_W-1:0] stackQ [MAX_TL];
  logic [TL_W-1:0]    tlQ;
  logic               ovflQ;

  logic doPush, doReject, doPop, doLd;
  logic [IDX_W-1:0]   popIdx;
  logic [STATE_W-1:0] enterState;

  always_comb begin
    doPush   = trapEnter && (tlQ < TL_W'(MAX_TL));
    doReject = trapEnter && (tlQ == TL_W'(MAX_TL));
    doPop    = !trapEnter && trapExit && (tlQ != '0);
    doLd     = !trapEnter && !trapExit && stateLd;
    popIdx   = IDX_W'(tlQ - 1'b1);
    enterState = stateQ;
    enterState[IG_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= '0;
      tlQ    <= '0;
      ovflQ  <= 1'b0;
    end else begin
      ovflQ <= doReject;
      if (doPush) begin
        stateQ <= enterState;
        tlQ    <= tlQ + 1'b1;
      end else if (doPop) begin
        stateQ <= stackQ[popIdx];
        tlQ    <= tlQ - 1'b1;
      end else if (doLd) begin
        stateQ <= stateLdData;
      end
    end
  end

  for (genvar i = 0; i < MAX_TL; i++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN)
        stackQ[i] <= '0;
      else if (doPush && (tlQ == TL_W'(i)))
        stackQ[i] <= stateQ;
    end
  end

  always_comb begin
    strobe.bankSel = stateQ[IG_BIT];
    strobe.wrEn    = wrEn;
  end

  assign stateOut  = stateQ;
  assign trapLevel = tlQ;
  assign stackOvfl = ovflQ;

  // R6
  level_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    tlQ <= TL_W'(MAX_TL));

  // R2
  ig_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trapEnter && tlQ < TL_W'(MAX_TL)) |=> (stateQ[IG_BIT] && tlQ == $past(tlQ) + 1'b1));

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trapEnter && tlQ == TL_W'(MAX_TL)) |=> (ovflQ && $stable(tlQ) && $stable(stateQ)));

  // R3
  pop_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!trapEnter && trapExit && tlQ != '0) |=> (tlQ == $past(tlQ) - 1'b1));

  // R9
  idle_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!trapEnter && trapExit && tlQ == '0) |=> ($stable(stateQ) && tlQ == '0));
endmodule

// File: rtl/gregDatapath.sv
module gregDatapath
  import gregPkg::*;
#(
  parameter int DATA_W = 64,
  parameter int NREG   = 8,
  parameter int NRD    = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  dpStrobe_t                     strobe,
  input  logic [$clog2(NREG)-1:0]       wrAddr,
  input  logic [DATA_W-1:0]             wrData,
  input  logic [NRD-1:0][$clog2(NREG)-1:0] rdAddr,
  output logic [NRD-1:0][DATA_W-1:0]    rdData
);
  localparam int ADDR_W = $clog2(NREG);

  logic [DATA_W-1:0] bankQ [2][NREG];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int b = 0; b < 2; b++)
        for (int r = 0; r < NREG; r++)
          bankQ[b][r] <= '0;
    end else if (strobe.wrEn && (wrAddr != '0)) begin
      bankQ[strobe.bankSel][wrAddr] <= wrData;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : gRd
    always_comb begin
      if (rdAddr[p] == '0)
        rdData[p] = '0;
      else if (strobe.wrEn && (wrAddr == rdAddr[p]))
        rdData[p] = wrData;
      else
        rdData[p] = bankQ[strobe.bankSel][rdAddr[p]];
    end
  end

  // R5
  write_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && wrAddr != '0) |=>
      ((rdAddr[0] != $past(wrAddr)) || !$stable(strobe.bankSel) ||
       (strobe.wrEn && wrAddr == rdAddr[0]) || (rdData[0] == $past(wrData))));

  // R4
  zero_reg_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr[1] == ADDR_W'(0)) |-> (rdData[1] == '0));
endmodule

// File: rtl/gregTrapFile.sv
module gregTrapFile
  import gregPkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int STATE_W = 4,
  parameter int MAX_TL  = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                trapEnter,
  input  logic                trapExit,
  input  logic                stateLd,
  input  logic [STATE_W-1:0]  stateLdData,
  input  logic                wrEn,
  input  logic [2:0]          wrAddr,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [2:0]          rdAddrA,
  output logic [DATA_W-1:0]   rdDataA,
  input  logic [2:0]          rdAddrB,
  output logic [DATA_W-1:0]   rdDataB,
  output logic [STATE_W-1:0]  stateOut,
  output logic [$clog2(MAX_TL+1)-1:0] trapLevel,
  output logic                stackOvfl
);
  localparam int NREG = 8;
  localparam int NRD  = 2;

  dpStrobe_t strobe;
  logic [NRD-1:0][2:0]        rdAddrV;
  logic [NRD-1:0][DATA_W-1:0] rdDataV;

  assign rdAddrV = {rdAddrB, rdAddrA};
  assign rdDataA = rdDataV[0];
  assign rdDataB = rdDataV[1];

  gregCtrl #(.STATE_W(STATE_W), .IG_BIT(0), .MAX_TL(MAX_TL)) uCtrl (
    .clk(clk), .rstN(rstN), .trapEnter(trapEnter), .trapExit(trapExit),
    .stateLd(stateLd), .stateLdData(stateLdData), .wrEn(wrEn),
    .strobe(strobe), .stateOut(stateOut), .trapLevel(trapLevel),
    .stackOvfl(stackOvfl)
  );

  gregDatapath #(.DATA_W(DATA_W), .NREG(NREG), .NRD(NRD)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddrV), .rdData(rdDataV)
  );
endmodule

// File: tb/sim_gregTrapFile.sv
`timescale 1ns/1ps
module sim_gregTrapFile;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        trapEnter = 0, trapExit = 0, stateLd = 0, wrEn = 0;
  logic [3:0]  stateLdData = '0;
  logic [2:0]  wrAddr = '0, rdAddrA = '0, rdAddrB = '0;
  logic [63:0] wrData = '0;
  logic [63:0] rdDataA, rdDataB;
  logic [3:0]  stateOut;
  logic [2:0]  trapLevel;
  logic        stackOvfl;

  always #2.5 clk = ~clk;

  gregTrapFile u0 (
    .clk(clk), .rstN(rstN), .trapEnter(trapEnter), .trapExit(trapExit),
    .stateLd(stateLd), .stateLdData(stateLdData), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .rdAddrA(rdAddrA), .rdDataA(rdDataA),
    .rdAddrB(rdAddrB), .rdDataB(rdDataB), .stateOut(stateOut),
    .trapLevel(trapLevel), .stackOvfl(stackOvfl)
  );

  int checks = 0, fails = 0;
  logic [63:0] mReg [2][8];
  logic [3:0]  mState;
  logic [3:0]  mStack [4];
  int          mTl;
  logic        mOvfl;

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] expRead(input logic [2:0] a);
    if (a == 0) return '0;
    if (wrEn && wrAddr == a) return wrData;
    return mReg[mState[0]][a];
  endfunction

  task automatic modelReset();
    for (int b = 0; b < 2; b++) for (int r = 0; r < 8; r++) mReg[b][r] = '0;
    for (int i = 0; i < 4; i++) mStack[i] = '0;
    mState = '0; mTl = 0; mOvfl = 0;
  endtask

  task automatic modelEdge();
    if (wrEn && wrAddr != 0) mReg[mState[0]][wrAddr] = wrData;
    mOvfl = 0;
    if (trapEnter) begin
      if (mTl < 4) begin
        mStack[mTl] = mState; mTl++; mState[0] = 1'b1;
      end else mOvfl = 1;
    end else if (trapExit) begin
      if (mTl > 0) begin mTl--; mState = mStack[mTl]; end
    end else if (stateLd) mState = stateLdData;
  endtask

  // one cycle: drive at negedge, check before posedge, update model at posedge
  task automatic step(input string tag, input logic en, input logic ex, input logic ld,
                      input logic [3:0] ldd, input logic we, input logic [2:0] wa,
                      input logic [63:0] wd, input logic [2:0] ra, input logic [2:0] rb);
    @(negedge clk);
    trapEnter = en; trapExit = ex; stateLd = ld; stateLdData = ldd;
    wrEn = we; wrAddr = wa; wrData = wd; rdAddrA = ra; rdAddrB = rb;
    #1;
    chk(tag, "rdDataA", rdDataA, expRead(ra));
    chk(tag, "rdDataB", rdDataB, expRead(rb));
    chk(tag, "stateOut", 64'(stateOut), 64'(mState));
    chk(tag, "trapLevel", 64'(trapLevel), 64'(mTl));
    chk(tag, "stackOvfl", 64'(stackOvfl), 64'(mOvfl));
    @(posedge clk);
    modelEdge();
  endtask

  task automatic idle(input string tag, input logic [2:0] ra, input logic [2:0] rb);
    step(tag, 0, 0, 0, 4'h0, 0, 3'd0, 64'd0, ra, rb);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    // R1 reset state
    idle("R1", 3'd1, 3'd7);
    idle("R1", 3'd3, 3'd4);
    // fill normal bank
    step("R5", 0, 0, 0, 4'h0, 1, 3'd3, 64'hAAAA_0003, 3'd3, 3'd0);
    // R8 write on the entry cycle lands in normal bank
    step("R8", 1, 0, 0, 4'h0, 1, 3'd4, 64'hBBBB_0004, 3'd3, 3'd4);
    // R2 now in alternate bank; R5 alternate bank is empty
    idle("R2", 3'd4, 3'd3);
    step("R5", 0, 0, 0, 4'h0, 1, 3'd4, 64'hCCCC_0004, 3'd4, 3'd3);
    idle("R5", 3'd4, 3'd3);
    // R4 global 0
    step("R4", 0, 0, 0, 4'h0, 1, 3'd0, 64'hFFFF_FFFF, 3'd0, 3'd0);
    idle("R4", 3'd0, 3'd4);
    // R7 bypass
    step("R7", 0, 0, 0, 4'h0, 1, 3'd5, 64'hDDDD_0005, 3'd5, 3'd5);
    // R3 exit restores normal bank
    step("R3", 0, 1, 0, 4'h0, 0, 3'd0, 64'd0, 3'd4, 3'd5);
    idle("R3", 3'd4, 3'd3);
    // R9 exit at level 0 ignored, with a load also blocked (R10)
    step("R9", 0, 1, 1, 4'hE, 0, 3'd0, 64'd0, 3'd4, 3'd1);
    idle("R9", 3'd4, 3'd1);
    // R11 direct load
    step("R11", 0, 0, 1, 4'h6, 0, 3'd0, 64'd0, 3'd3, 3'd4);
    idle("R11", 3'd3, 3'd4);
    // R6 fill the stack and overflow
    for (int i = 0; i < 5; i++) step("R6", 1, 0, 0, 4'h0, 0, 3'd0, 64'd0, 3'd3, 3'd4);
    idle("R6", 3'd3, 3'd4);
    idle("R6", 3'd3, 3'd4);
    // R10 entry beats exit; exit beats load
    step("R10", 0, 1, 0, 4'h0, 0, 3'd0, 64'd0, 3'd1, 3'd2);
    step("R10", 1, 1, 1, 4'h9, 0, 3'd0, 64'd0, 3'd1, 3'd2);
    step("R10", 0, 1, 1, 4'h9, 0, 3'd0, 64'd0, 3'd1, 3'd2);
    idle("R10", 3'd1, 3'd2);
    // R3 unwind fully back to the loaded state
    for (int i = 0; i < 4; i++) step("R3", 0, 1, 0, 4'h0, 0, 3'd0, 64'd0, 3'd3, 3'd4);
    idle("R3", 3'd3, 3'd4);
    // constrained random mix
    for (int n = 0; n < 3000; n++) begin
      logic en, ex, ld, we;
      en = ($urandom % 8) == 0;
      ex = ($urandom % 6) == 0;
      ld = ($urandom % 20) == 0;
      we = ($urandom % 2) == 0;
      step("R5", en, ex, ld, 4'($urandom), we, 3'($urandom), {$urandom, $urandom},
           3'($urandom), 3'($urandom));
    end
    idle("R5", 3'd1, 3'd2);
    summary();
    $finish;
  end
endmodule